// File: doc/BRIEF.md
# Serial Register Port with Indirect Readback

This block is the control port of a video processing device. An external host drives a chip select (active low), a serial clock and a data line into the block, and receives read data on a fourth line. Every access begins with an address byte and continues with one or more data bytes. Each data byte is committed to a small bank of 8-bit configuration registers, whose contents drive the rest of the chip.

Reading is indirect. The host first writes the number of the register it wants into a pointer register. In a second access it sends the address of the read-data window. During the next eight serial clocks the block shifts out the selected value, most significant bit first. The three serial inputs are brought into the system clock domain through a synchroniser chain, and all frame decoding runs on the system clock. The system clock must run at least four times faster than the serial clock.

The register bank sits at a parameterised base address. One register in it, at 0x12, carries the system settings, and bit 0 of that register selects which input byte lane carries luma.

Top module: `sreg_port`

## Requirements
- R1: A write access is an address byte followed by a data byte, each sent MSB first and sampled on the rising serial-clock edge. When the data byte completes, the register at that address takes the new value.
- R2: Further data bytes within one chip-select low period go to consecutive addresses, incrementing by one after each byte.
- R3: The pointer register is at address 0x70. After the address byte 0x80 is received, the value of the register named by the pointer is driven on `spi_sdo`, MSB first, changing after each falling serial-clock edge for the next eight clocks, and low afterwards.
- R4: `spi_sdo` is low while chip select is high, and low during every byte that is not a read-out.
- R5: Raising chip select in the middle of a byte discards that byte and commits nothing. The next access starts again with an address byte.
- R6: A data byte sent to address 0x80 changes no register and does not change the pointer.
- R7: The bank holds NUM_REGS registers starting at BASE_ADDR (default 0x10 to 0x17). Writes to addresses outside the bank and outside 0x70 have no effect. A read through a pointer value outside the bank returns 0, and a pointer value of 0x70 returns the pointer itself. `lane_swap_o` is bit 0 of the register at 0x12.
- R8: After reset every register and the pointer are 0, and `spi_sdo` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial read data to the host |
| cfg_o | output | NUM_REGS*8 | Flattened register bank, register i at bits [8i+7:8i] |
| lane_swap_o | output | 1 | Input byte-lane select, bit 0 of register 0x12 |

## Verification
The bench uses the default parameters. These give eight registers from 0x10 to 0x17, two synchroniser stages and auto-increment enabled, so a burst that starts at 0x16 runs off the top of the bank into the unmapped address 0x18. The serial clock period is sixteen system cycles. This leaves room for the synchroniser latency, so the bench can sample read data just before each rising edge, as a host would. Aborted frames are cut both in the address byte and in the data byte. Every register read back through the indirect window is compared with a shadow copy kept by the bench.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CNT_W  = $clog2(BYTE_W);

   typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_e;

   typedef struct packed {
      logic              en;
      logic [BYTE_W-1:0] addr;
      logic [BYTE_W-1:0] data;
   } wr_req_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int unsigned     WIDTH   = 3,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RDAT_ADDR = 8'h80,
   parameter bit                AUTO_INC  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [BYTE_W-1:0] rd_data_i,
   output wr_req_t           wr_o,
   output logic              sdo_o
);
   logic              sclk_q;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] sh;
   logic [BYTE_W-1:0] byte_w;
   logic [BYTE_W-1:0] addr_q, next_addr;
   logic [BYTE_W-1:0] osr;
   phase_e            ph;
   logic              rd_act;

   assign rise   = sclk_s & ~sclk_q;
   assign fall   = ~sclk_s & sclk_q;
   assign byte_w = {sh, sdi_s};

   if (AUTO_INC) begin : g_inc
      assign next_addr = addr_q + 8'd1;
   end else begin : g_hold
      assign next_addr = addr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         bit_cnt <= '0;
         sh      <= '0;
         addr_q  <= '0;
         osr     <= '0;
         ph      <= PH_ADDR;
         rd_act  <= 1'b0;
         sdo_o   <= 1'b0;
         wr_o    <= '0;
      end else begin
         sclk_q  <= sclk_s;
         wr_o.en <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            ph      <= PH_ADDR;
            osr     <= '0;
            rd_act  <= 1'b0;
            sdo_o   <= 1'b0;
         end else begin
            if (rise) begin
               sh      <= byte_w[BYTE_W-2:0];
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                  if (ph == PH_ADDR) begin
                     addr_q <= byte_w;
                     ph     <= PH_DATA;
                     if (byte_w == RDAT_ADDR) begin
                        osr    <= rd_data_i;
                        rd_act <= 1'b1;
                     end
                  end else begin
                     wr_o.en   <= 1'b1;
                     wr_o.addr <= addr_q;
                     wr_o.data <= byte_w;
                     addr_q    <= next_addr;
                  end
               end
            end
            if (fall) begin
               sdo_o <= osr[BYTE_W-1];
               osr   <= {osr[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
   import sreg_pkg::*;
#(
   parameter int unsigned       NUM_REGS  = 8,
   parameter logic [BYTE_W-1:0] BASE_ADDR = 8'h10,
   parameter logic [BYTE_W-1:0] PTR_ADDR  = 8'h70
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  wr_req_t                    wr_i,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_o,
   output logic [BYTE_W-1:0]          rd_data_o
);
   logic [NUM_REGS-1:0] reg_we;
   logic [BYTE_W-1:0]   ptr_q;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [BYTE_W-1:0] ADDR = BASE_ADDR + BYTE_W'(g);
      logic [BYTE_W-1:0] q;
      assign reg_we[g] = wr_i.en && (wr_i.addr == ADDR);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= '0;
         else if (reg_we[g]) q <= wr_i.data;
      end
      assign cfg_o[g*BYTE_W +: BYTE_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ptr_q <= '0;
      else if (wr_i.en && (wr_i.addr == PTR_ADDR))  ptr_q <= wr_i.data;
   end

   always_comb begin
      rd_data_o = '0;
      if (ptr_q == PTR_ADDR) rd_data_o = ptr_q;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (ptr_q == BASE_ADDR + BYTE_W'(i)) rd_data_o = cfg_o[i*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
   import sreg_pkg::*;
#(
   parameter int unsigned       NUM_REGS     = 8,
   parameter logic [BYTE_W-1:0] BASE_ADDR    = 8'h10,
   parameter logic [BYTE_W-1:0] PTR_ADDR     = 8'h70,
   parameter logic [BYTE_W-1:0] RDAT_ADDR    = 8'h80,
   parameter int unsigned       LANE_REG_OFS = 2,
   parameter int unsigned       SYNC_STAGES  = 2,
   parameter bit                AUTO_INC     = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_cs_n,
   input  logic                       spi_sclk,
   input  logic                       spi_sdi,
   output logic                       spi_sdo,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_o,
   output logic                       lane_swap_o
);
   localparam int unsigned TOP_ADDR = int'(BASE_ADDR) + NUM_REGS;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be two or more");
   end
   if (NUM_REGS < 1 || TOP_ADDR > 256) begin : g_bad_bank
      $error("register bank does not fit the address space");
   end
   if (LANE_REG_OFS >= NUM_REGS) begin : g_bad_lane
      $error("lane register lies outside the bank");
   end
   if ((PTR_ADDR >= BASE_ADDR && int'(PTR_ADDR) < TOP_ADDR) ||
       (RDAT_ADDR >= BASE_ADDR && int'(RDAT_ADDR) < TOP_ADDR) ||
       PTR_ADDR == RDAT_ADDR) begin : g_bad_map
      $error("pointer or read window overlaps another address");
   end

   logic [2:0]        sync_q;
   wr_req_t           wr_req;
   logic [BYTE_W-1:0] rd_data;

   sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_cs_n, spi_sclk, spi_sdi}),
      .q_o   (sync_q)
   );

   sreg_frame #(.RDAT_ADDR(RDAT_ADDR), .AUTO_INC(AUTO_INC)) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (sync_q[2]),
      .sclk_s    (sync_q[1]),
      .sdi_s     (sync_q[0]),
      .rd_data_i (rd_data),
      .wr_o      (wr_req),
      .sdo_o     (spi_sdo)
   );

   sreg_bank #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR), .PTR_ADDR(PTR_ADDR)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_req),
      .cfg_o     (cfg_o),
      .rd_data_o (rd_data)
   );

   assign lane_swap_o = cfg_o[LANE_REG_OFS*BYTE_W];
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
   import sreg_pkg::*;
#(
   parameter int unsigned       NUM_REGS  = 8,
   parameter logic [BYTE_W-1:0] PTR_ADDR  = 8'h70,
   parameter logic [BYTE_W-1:0] RDAT_ADDR = 8'h80
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs_s,
   input logic                       sdo,
   input logic                       rd_act,
   input wr_req_t                    wr,
   input logic [NUM_REGS-1:0]        reg_we,
   input logic [BYTE_W-1:0]          ptr,
   input logic [NUM_REGS*BYTE_W-1:0] cfg
);
   a_r4_sdo_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdo);

   a_r3_sdo_only_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
      sdo |-> rd_act);

   a_r5_commit_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      wr.en |-> !$past(cs_s));

   a_r6_window_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.en && wr.addr == RDAT_ADDR) |=> ($stable(cfg) && $stable(ptr)));

   a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we));

   a_r7_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we == '0) |=> $stable(cfg));

   a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr.en && wr.addr == PTR_ADDR) |=> $stable(ptr));
endmodule

bind sreg_port sreg_port_chk #(
   .NUM_REGS(NUM_REGS), .PTR_ADDR(PTR_ADDR), .RDAT_ADDR(RDAT_ADDR)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_s   (sync_q[2]),
   .sdo    (spi_sdo),
   .rd_act (u_frm.rd_act),
   .wr     (wr_req),
   .reg_we (u_bank.reg_we),
   .ptr    (u_bank.ptr_q),
   .cfg    (cfg_o)
);

// File: tb/sim_sreg_port.sv
`timescale 1ns/1ps
module sim_sreg_port;
   localparam int NREG = 8;
   localparam int BASE = 16;
   localparam int HALF = 64;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic sdo, lane;
   logic [NREG*8-1:0] cfg;
   int total = 0, bad = 0;
   logic [7:0] sh [NREG];
   logic [7:0] ptr_m = 8'h00;
   logic [7:0] rx;

   always #4 clk = ~clk;

   sreg_port #(.NUM_REGS(NREG)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
      .spi_sdi(sdi), .spi_sdo(sdo), .cfg_o(cfg), .lane_swap_o(lane)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [7:0] p);
      if (p == 8'h70) return ptr_m;
      if (p >= BASE && p < BASE + NREG) return sh[p - BASE];
      return 8'h00;
   endfunction

   task automatic sh_wr(input logic [7:0] a, input logic [7:0] d);
      if (a >= BASE && a < BASE + NREG) sh[a - BASE] = d;
      if (a == 8'h70) ptr_m = d;
   endtask

   task automatic send(input logic [7:0] tx, input int n, output logic [7:0] r);
      r = 8'h00;
      for (int i = 7; i >= 8 - n; i--) begin
         sdi = tx[i];
         #HALF;
         r[i] = sdo;
         sclk = 1'b1;
         #HALF;
         sclk = 1'b0;
      end
   endtask

   task automatic open_f();
      cs_n = 1'b0;
      #200;
   endtask

   task automatic close_f();
      #HALF;
      cs_n = 1'b1;
      #1000;
   endtask

   task automatic wr1(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] r;
      open_f(); send(a, 8, r); send(d, 8, r); close_f();
      sh_wr(a, d);
   endtask

   task automatic rd_ptr(input logic [7:0] p, output logic [7:0] r);
      logic [7:0] dummy;
      wr1(8'h70, p);
      open_f(); send(8'h80, 8, dummy); send(8'h00, 8, r); close_f();
   endtask

   task automatic chk_bank(input string req);
      for (int i = 0; i < NREG; i++) chk(req, cfg[i*8 +: 8], sh[i]);
   endtask

   task automatic t_reset();
      chk("R8 bank cleared", cfg, '0);
      chk("R8 sdo low", sdo, 1'b0);
      chk("R8 lane low", lane, 1'b0);
      rd_ptr(8'h70, rx);
      chk("R8 pointer readback", rx, 8'h70);
   endtask

   task automatic t_single();
      wr1(8'h10, 8'hA5);
      chk("R1 single write 0x10", cfg[7:0], 8'hA5);
      wr1(8'h12, 8'h01);
      chk("R7 lane select set", lane, 1'b1);
      wr1(8'h12, 8'hFE);
      chk("R7 lane select clear", lane, 1'b0);
      chk_bank("R1 bank after singles");
   endtask

   task automatic t_burst();
      logic [7:0] r;
      open_f(); send(8'h13, 8, r);
      send(8'h11, 8, r); send(8'h22, 8, r); send(8'h33, 8, r);
      close_f();
      sh_wr(8'h13, 8'h11); sh_wr(8'h14, 8'h22); sh_wr(8'h15, 8'h33);
      chk_bank("R2 burst 0x13..0x15");
      open_f(); send(8'h16, 8, r);
      send(8'h5A, 8, r); send(8'hC3, 8, r); send(8'h99, 8, r);
      close_f();
      sh_wr(8'h16, 8'h5A); sh_wr(8'h17, 8'hC3);
      chk_bank("R2 burst past bank top");
   endtask

   task automatic t_read();
      logic [7:0] r, tail;
      for (int a = BASE; a < BASE + NREG; a++) begin
         rd_ptr(8'(a), r);
         chk($sformatf("R3 read 0x%0h", a), r, exp_rd(8'(a)));
      end
      rd_ptr(8'h40, r);
      chk("R7 unmapped read zero", r, 8'h00);
      wr1(8'h70, 8'h16);
      open_f(); send(8'h80, 8, r); send(8'h00, 8, r); send(8'h00, 8, tail); close_f();
      chk("R3 read in frame", r, sh[6]);
      chk("R3 sdo low after readout", tail, 8'h00);
   endtask

   task automatic t_idle();
      logic [7:0] r1, r2;
      chk("R4 sdo low deselected", sdo, 1'b0);
      open_f(); send(8'h11, 8, r1); send(8'h6C, 8, r2); close_f();
      sh_wr(8'h11, 8'h6C);
      chk("R4 sdo low in address byte", r1, 8'h00);
      chk("R4 sdo low in data byte", r2, 8'h00);
   endtask

   task automatic t_abort();
      logic [7:0] r;
      open_f(); send(8'h16, 8, r); send(8'hFF, 3, r); close_f();
      chk("R5 data byte abort", cfg[6*8 +: 8], sh[6]);
      open_f(); send(8'h10, 5, r); close_f();
      wr1(8'h11, 8'h3C);
      chk("R5 restart after address abort", cfg[1*8 +: 8], 8'h3C);
      chk_bank("R5 bank after aborts");
   endtask

   task automatic t_window();
      logic [7:0] r;
      wr1(8'h70, 8'h14);
      open_f(); send(8'h80, 8, r); send(8'hFF, 8, r); close_f();
      chk_bank("R6 window write leaves bank");
      open_f(); send(8'h80, 8, r); send(8'h00, 8, r); close_f();
      chk("R6 pointer unchanged", r, sh[4]);
   endtask

   task automatic t_unmapped();
      wr1(8'h40, 8'hEE);
      wr1(8'h0F, 8'hEE);
      wr1(8'h18, 8'hEE);
      chk_bank("R7 unmapped writes inert");
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) sh[i] = 8'h00;
      #40 rst_n = 1'b1;
      #40;
      t_reset();
      t_single();
      t_burst();
      t_read();
      t_idle();
      t_abort();
      t_window();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule